// File: doc/BRIEF.md
# Coherent Seconds/Milliseconds Time Counter

This block is a free-running time counter that keeps two counts: whole seconds, and milliseconds within the current second. Both advance from a single-cycle 1 kHz tick enable that arrives in the bus clock domain. There is no stop control, so the counter runs for as long as it is out of reset.

Software reads the counts through a small 32-bit read port. Each read returns data one cycle after the request. A seconds count and a milliseconds count that are read separately can straddle a rollover and give a wrong timestamp.

To avoid this, a read of the milliseconds register also copies the live seconds count into a shadow register in the same cycle. Software reads milliseconds first and the shadow second. It can then combine them as seconds × 1000 + milliseconds and get a timestamp that belongs together.

Top module: `rtc_latched_time`

## Requirements
- R1: After reset, the seconds count, the milliseconds count and the shadow are all zero, so reads of all three registers return 0.
- R2: Each cycle with `tick_1k` high moves the milliseconds count up by one when it is below 999. Without a tick, neither count changes.
- R3: A tick while the milliseconds count is 999 sets it to 0 and adds one to the seconds count on the same clock edge.
- R4: A read at byte offset 0x10 returns the milliseconds count, zero-extended to 32 bits, on `rd_data` in the cycle after the request. The same edge copies the live seconds count into the shadow.
- R5: When a milliseconds read and a rollover tick fall in the same cycle, the returned milliseconds value (999) and the captured shadow seconds both come from before the rollover.
- R6: A read at byte offset 0x0C returns the shadow seconds value. The shadow changes only on a milliseconds read; reads at 0x08 or 0x0C leave it unchanged.
- R7: A read at byte offset 0x08 returns the live seconds count in the cycle after the request.
- R8: A read at any other offset returns 0.
- R9: Reads never stall or disturb counting. A tick in a read cycle is counted like any other tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_1k | input | 1 | Single-cycle millisecond advance enable |
| rd_en | input | 1 | Read request strobe |
| rd_addr | input | ADDR_W (8) | Byte offset of the register to read |
| rd_data | output | DATA_W (32) | Read result, valid the cycle after `rd_en` |

## Verification
The bench aims most directly at the millisecond read that coincides with the 999-to-0 tick. A design that lets the shadow take the post-increment seconds value would return 999 paired with the next second, which is a timestamp one second late. It also checks shadow reads after seconds have moved on. A shadow that follows live seconds, or that is refreshed by seconds reads, shows up as a mismatch there. Randomly mixed ticks and reads over several rollovers catch an off-by-one wrap point, a lost tick during a read, or a nonzero value from an unmapped offset.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] OFS_SEC_LIVE   = 8'h08;
  localparam logic [7:0] OFS_SEC_SHADOW = 8'h0C;
  localparam logic [7:0] OFS_MSEC       = 8'h10;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_LIVE,
    SEL_SHADOW,
    SEL_MSEC
  } rd_sel_e;
endpackage

// File: rtl/rtc_ms_counter.sv
module rtc_ms_counter #(
  parameter int MS_PER_SEC = 1000,
  localparam int MS_W = $clog2(MS_PER_SEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  output logic [MS_W-1:0] ms_cnt,
  output logic            carry
);
  localparam logic [MS_W-1:0] LAST = MS_W'(MS_PER_SEC - 1);

  logic [MS_W-1:0] ms_d;
  logic            ms_en;

  // wrap happens on the tick at the last millisecond
  assign carry = tick && (ms_cnt == LAST);
  assign ms_en = tick;

  always_comb begin
    if (carry) ms_d = '0;
    else       ms_d = ms_cnt + MS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ms_cnt <= '0;
    else if (ms_en) ms_cnt <= ms_d;
  end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [SEC_W-1:0] sec_cnt
);
  logic [SEC_W-1:0] sec_d;

  assign sec_d = sec_cnt + SEC_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sec_cnt <= '0;
    else if (inc) sec_cnt <= sec_d;
  end
endmodule

// File: rtl/rtc_read_port.sv
module rtc_read_port
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int SEC_W  = 32,
  parameter int MS_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [SEC_W-1:0]  sec_cnt,
  input  logic [MS_W-1:0]   ms_cnt,
  output logic [DATA_W-1:0] rd_data,
  output logic [SEC_W-1:0]  shadow_sec
);
  rd_sel_e           sel;
  logic [DATA_W-1:0] data_d;
  logic              shadow_en;

  always_comb begin
    if (rd_addr == ADDR_W'(OFS_SEC_LIVE))        sel = SEL_LIVE;
    else if (rd_addr == ADDR_W'(OFS_SEC_SHADOW)) sel = SEL_SHADOW;
    else if (rd_addr == ADDR_W'(OFS_MSEC))       sel = SEL_MSEC;
    else                                         sel = SEL_NONE;
  end

  always_comb begin
    case (sel)
      SEL_LIVE:   data_d = DATA_W'(sec_cnt);
      SEL_SHADOW: data_d = DATA_W'(shadow_sec);
      SEL_MSEC:   data_d = DATA_W'(ms_cnt);
      default:    data_d = '0;
    endcase
  end

  // capture uses the pre-edge seconds, same edge as the returned ms value
  assign shadow_en = rd_en && (sel == SEL_MSEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow_sec <= '0;
    else if (shadow_en) shadow_sec <= sec_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= data_d;
  end
endmodule

// File: rtl/rtc_latched_time.sv
module rtc_latched_time #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int MS_PER_SEC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1k,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SEC_W = DATA_W;
  localparam int MS_W  = $clog2(MS_PER_SEC);

  logic [MS_W-1:0]  ms_cnt;
  logic [SEC_W-1:0] sec_cnt;
  logic [SEC_W-1:0] shadow_sec;
  logic             ms_carry;

  rtc_ms_counter #(.MS_PER_SEC(MS_PER_SEC)) u_ms (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_1k),
    .ms_cnt (ms_cnt),
    .carry  (ms_carry)
  );

  rtc_sec_counter #(.SEC_W(SEC_W)) u_sec (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (ms_carry),
    .sec_cnt (sec_cnt)
  );

  rtc_read_port #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .SEC_W  (SEC_W),
    .MS_W   (MS_W)
  ) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .sec_cnt    (sec_cnt),
    .ms_cnt     (ms_cnt),
    .rd_data    (rd_data),
    .shadow_sec (shadow_sec)
  );
endmodule

// File: rtl/rtc_latched_time_chk.sv
module rtc_latched_time_chk
  import rtc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int MS_PER_SEC = 1000,
  localparam int SEC_W = DATA_W,
  localparam int MS_W  = $clog2(MS_PER_SEC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1k,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [MS_W-1:0]   ms_cnt,
  input logic [SEC_W-1:0]  sec_cnt,
  input logic [SEC_W-1:0]  shadow_sec
);
  localparam logic [MS_W-1:0] LAST = MS_W'(MS_PER_SEC - 1);

  logic ms_read;
  assign ms_read = rd_en && (rd_addr == ADDR_W'(OFS_MSEC));

  // R2
  ms_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ms_cnt <= LAST);

  // R2
  ms_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1k && ms_cnt != LAST) |=> (ms_cnt == $past(ms_cnt) + MS_W'(1)) && $stable(sec_cnt));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_1k |=> $stable(ms_cnt) && $stable(sec_cnt));

  // R3
  rollover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1k && ms_cnt == LAST) |=> (ms_cnt == '0) && (sec_cnt == $past(sec_cnt) + SEC_W'(1)));

  // R4
  ms_read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ms_read |=> (shadow_sec == $past(sec_cnt)) && (rd_data == DATA_W'($past(ms_cnt))));

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_read |=> $stable(shadow_sec));
endmodule

bind rtc_latched_time rtc_latched_time_chk #(
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .MS_PER_SEC (MS_PER_SEC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_1k    (tick_1k),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .ms_cnt     (ms_cnt),
  .sec_cnt    (sec_cnt),
  .shadow_sec (shadow_sec)
);

// File: tb/sim_rtc_latched_time.sv
module sim_rtc_latched_time;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_1k;
  logic        rd_en;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;

  int nchk = 0;
  int nerr = 0;

  int          m_ms  = 0;
  logic [31:0] m_sec = '0;
  logic [31:0] m_sh  = '0;

  always #10 clk = ~clk;

  rtc_latched_time u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_1k (tick_1k),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h08:   return m_sec;
      8'h0C:   return m_sh;
      8'h10:   return 32'(m_ms);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_for(input logic [7:0] a);
    case (a)
      8'h08:   return "R7";
      8'h0C:   return "R6";
      8'h10:   return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: rd_data=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; drives one cycle and checks at the next falling edge
  task automatic step(input bit tk, input bit rd, input logic [7:0] a, input string req);
    logic [31:0] e;
    e = exp_read(a);
    tick_1k = tk;
    rd_en   = rd;
    rd_addr = a;
    @(negedge clk);
    if (rd) chk(req, rd_data, e);
    if (rd && a == 8'h10) m_sh = m_sec;
    if (tk) begin
      if (m_ms == 999) begin
        m_ms  = 0;
        m_sec = m_sec + 32'd1;
      end else begin
        m_ms = m_ms + 1;
      end
    end
    tick_1k = 1'b0;
    rd_en   = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00, "");
  endtask

  initial begin
    #(20 * 150000);
    nerr++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n   = 1'b0;
    tick_1k = 1'b0;
    rd_en   = 1'b0;
    rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    step(1'b0, 1'b1, 8'h08, "R1");
    step(1'b0, 1'b1, 8'h0C, "R1");
    step(1'b0, 1'b1, 8'h10, "R1");

    // R2 count and hold
    ticks(5);
    step(1'b0, 1'b1, 8'h10, "R2");
    step(1'b0, 1'b0, 8'h00, "");
    step(1'b0, 1'b0, 8'h00, "");
    step(1'b0, 1'b1, 8'h10, "R2");

    // R9 tick during a read still counts
    step(1'b1, 1'b1, 8'h10, "R9");
    step(1'b0, 1'b1, 8'h10, "R9");

    // R3 rollover: bring ms to 999 then tick
    ticks(999 - m_ms);
    step(1'b0, 1'b1, 8'h10, "R3");
    step(1'b1, 1'b0, 8'h00, "");
    step(1'b0, 1'b1, 8'h10, "R3");
    step(1'b0, 1'b1, 8'h08, "R3");

    // R5 read ms on the rollover tick: 999 with pre-rollover seconds
    ticks(999 - m_ms);
    step(1'b1, 1'b1, 8'h10, "R5");
    step(1'b0, 1'b1, 8'h0C, "R5");
    chk("R5", rd_data, 32'd1);
    step(1'b0, 1'b1, 8'h08, "R7");
    chk("R7", rd_data, 32'd2);

    // R6 seconds and shadow reads leave the shadow alone
    step(1'b0, 1'b1, 8'h08, "R6");
    step(1'b0, 1'b1, 8'h0C, "R6");
    step(1'b0, 1'b1, 8'h0C, "R6");

    // R8 unmapped offsets
    step(1'b0, 1'b1, 8'h04, "R8");
    step(1'b0, 1'b1, 8'hFF, "R8");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      bit tk;
      bit rd;
      tk = ($urandom_range(7) != 0);
      rd = ($urandom_range(1) != 0);
      case ($urandom_range(3))
        0: a = 8'h08;
        1: a = 8'h0C;
        2: a = 8'h10;
        default: a = 8'($urandom_range(255));
      endcase
      step(tk, rd, a, tag_for(a));
    end

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule